// File: doc/BRIEF.md
# Self-Oscillating Full-Bridge Gate Sequencer

This block generates the four gate commands of a full bridge (two low-side and two high-side switches) from a free-running digital ramp. The ramp is an up/down counter that takes the place of a timing capacitor. While the ramp climbs between one-third and two-thirds of full scale, one diagonal pair conducts: low-side 1 with high-side 2. While it falls back, the other pair conducts: low-side 2 with high-side 1. Every hand-over inserts a fixed all-off gap. On each start the block first holds both low sides on, so that the high-side bootstrap supplies can charge before any high-side pulse.

Three control inputs steer it. A supply-good flag comes from an undervoltage comparator and is expected to be synchronous to the clock. A shutdown request latches a fault until the supply flag drops. A ramp-hold request stops oscillation only for as long as it is held. The two requests are asynchronous and each passes through a two-flop synchronizer. Ramp full scale and deadtime are parameters counted in clock cycles. The defaults (600 and 100) give a 1.0 µs deadtime at 100 MHz. The block has no data stream, so every pin is a plain level.

Top module: `fb_bridge_seq`

## Requirements
- R1: While `supply_ok` is sampled low at a rising edge, all four gate outputs are low from that edge on, and the shutdown fault is cleared at that edge.
- R2: From the first edge at which the block runs (supply good, no fault, no hold), `drv_ls1` and `drv_ls2` are high and both high sides are low for FULL/3 cycles (precharge).
- R3: Every hand-over (precharge to pair A, pair A to pair B, pair B to pair A) passes through exactly DEAD cycles with all four outputs low.
- R4: Pair A is `drv_ls1`+`drv_hs2` and pair B is `drv_ls2`+`drv_hs1`. They alternate, starting with pair A, and each conducts for (2*FULL/3 - FULL/3 - DEAD) cycles. The period is 2*(2*FULL/3 - FULL/3) cycles.
- R5: `drv_ls1` and `drv_hs1` are never high together, nor are `drv_ls2` and `drv_hs2`. After a pair conducts, the next cycle has neither high side of the other pair on.
- R6: A high level on `shut_req` brings all outputs low from the third rising edge after it is applied. The block stays off after `shut_req` falls, until `supply_ok` goes low. When supply returns, the sequence restarts with precharge (R2).
- R7: A high level on `hold_req` brings all outputs low from the third rising edge after it is applied, with the ramp clamped to zero (below FULL/6). After release, the ramp restarts at the third rising edge with a full precharge, then a deadtime, then pair A.
- R8: Thresholds are derived as integer FULL/6, FULL/3 and 2*FULL/3. The ramp never exceeds 2*FULL/3 and turns round exactly at the upper and lower thresholds. FULL must be at least 6 and DEAD must be at least 1 and below 2*FULL/3 - FULL/3.
- R9: If a shutdown request and a hold release reach the logic in the same cycle, the shutdown wins. No precharge pulse or gate pulse appears, and the fault latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply-good flag from the undervoltage comparator (synchronous) |
| shut_req | input | 1 | Latched-shutdown request (asynchronous) |
| hold_req | input | 1 | Ramp-hold request for non-latched stop (asynchronous) |
| drv_ls1 | output | 1 | Low-side 1 gate command |
| drv_ls2 | output | 1 | Low-side 2 gate command |
| drv_hs1 | output | 1 | High-side 1 gate command |
| drv_hs2 | output | 1 | High-side 2 gate command |

## Verification
Two of the block's functions can meet in one cycle: the latched shutdown and the restart that follows a hold release. Both requests pass through synchronizers of equal depth. To provoke the collision, the bench drops `hold_req` and raises `shut_req` on the same clock phase, so both synchronized levels reach the logic together. The test passes only if the outputs stay all-low through the cycle where precharge would otherwise begin, and for a long window after it. A supply recycle must then be the thing that brings back the normal precharge.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

  typedef enum logic [2:0] {
    PH_OFF,
    PH_PRE,
    PH_GAP_A,
    PH_DRV_A,
    PH_GAP_B,
    PH_DRV_B
  } phase_e;

  typedef struct packed {
    logic ls1;
    logic ls2;
    logic hs1;
    logic hs2;
  } gates_t;

  function automatic gates_t gates_of(input phase_e ph);
    gates_t g;
    g = '0;
    case (ph)
      PH_PRE:   begin g.ls1 = 1'b1; g.ls2 = 1'b1; end
      PH_DRV_A: begin g.ls1 = 1'b1; g.hs2 = 1'b1; end
      PH_DRV_B: begin g.ls2 = 1'b1; g.hs1 = 1'b1; end
      default:  g = '0;
    endcase
    return g;
  endfunction

  function automatic int unsigned lvl_sixth(input int unsigned full);
    return full / 6;
  endfunction

  function automatic int unsigned lvl_low(input int unsigned full);
    return full / 3;
  endfunction

  function automatic int unsigned lvl_high(input int unsigned full);
    return (2 * full) / 3;
  endfunction

endpackage

// File: rtl/fbs_sync.sv
module fbs_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh[STAGES-1];

endmodule

// File: rtl/fbs_ramp.sv
module fbs_ramp
  import fbs_pkg::*;
#(
  parameter int unsigned FULL = 600,
  localparam int unsigned RW = $clog2(FULL + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          hold,
  output logic [RW-1:0] ramp,
  output logic          rising
);

  localparam logic [RW-1:0] LOW_V  = RW'(lvl_low(FULL));
  localparam logic [RW-1:0] HIGH_V = RW'(lvl_high(FULL));

  logic [RW-1:0] nxt;

  always_comb begin
    if (rising) nxt = ramp + 1'b1;
    else        nxt = ramp - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ramp   <= '0;
      rising <= 1'b1;
    end else if (!run || hold) begin
      ramp   <= '0;
      rising <= 1'b1;
    end else begin
      ramp <= nxt;
      if (rising && nxt == HIGH_V)      rising <= 1'b0;
      else if (!rising && nxt == LOW_V) rising <= 1'b1;
    end
  end

endmodule

// File: rtl/fbs_phase.sv
module fbs_phase
  import fbs_pkg::*;
#(
  parameter int unsigned FULL = 600,
  parameter int unsigned DEAD = 100,
  localparam int unsigned RW = $clog2(FULL + 1),
  localparam int unsigned DW = $clog2(DEAD + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          hold,
  input  logic [RW-1:0] ramp,
  input  logic          rising,
  output phase_e        phase
);

  localparam logic [RW-1:0] LOW_V  = RW'(lvl_low(FULL));
  localparam logic [RW-1:0] HIGH_V = RW'(lvl_high(FULL));
  localparam logic [DW-1:0] GAP_V  = DW'(DEAD - 1);

  logic [DW-1:0] gap_cnt;
  logic          at_low;
  logic          at_high;

  assign at_low  = rising && (ramp == LOW_V);
  assign at_high = !rising && (ramp == HIGH_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_OFF;
      gap_cnt <= '0;
    end else if (!run || hold) begin
      phase   <= PH_OFF;
      gap_cnt <= '0;
    end else begin
      case (phase)
        PH_OFF: phase <= PH_PRE;
        PH_PRE, PH_DRV_B: begin
          if (at_low) begin
            phase   <= PH_GAP_A;
            gap_cnt <= GAP_V;
          end
        end
        PH_DRV_A: begin
          if (at_high) begin
            phase   <= PH_GAP_B;
            gap_cnt <= GAP_V;
          end
        end
        PH_GAP_A: begin
          if (gap_cnt == '0) phase <= PH_DRV_A;
          else               gap_cnt <= gap_cnt - 1'b1;
        end
        PH_GAP_B: begin
          if (gap_cnt == '0) phase <= PH_DRV_B;
          else               gap_cnt <= gap_cnt - 1'b1;
        end
        default: phase <= PH_OFF;
      endcase
    end
  end

endmodule

// File: rtl/fb_bridge_seq.sv
module fb_bridge_seq
  import fbs_pkg::*;
#(
  parameter int unsigned FULL = 600,
  parameter int unsigned DEAD = 100,
  parameter int unsigned SYNC = 2,
  localparam int unsigned RW = $clog2(FULL + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic shut_req,
  input  logic hold_req,
  output logic drv_ls1,
  output logic drv_ls2,
  output logic drv_hs1,
  output logic drv_hs2
);

  logic          shut_s;
  logic          hold_s;
  logic          fault_q;
  logic          run;
  logic [RW-1:0] ramp_q;
  logic          rising_q;
  phase_e        phase_q;
  gates_t        gates;

  fbs_sync #(.STAGES(SYNC)) u_sync_shut (
    .clk(clk), .rst_n(rst_n), .d(shut_req), .q(shut_s)
  );

  fbs_sync #(.STAGES(SYNC)) u_sync_hold (
    .clk(clk), .rst_n(rst_n), .d(hold_req), .q(hold_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          fault_q <= 1'b0;
    else if (!supply_ok) fault_q <= 1'b0;
    else if (shut_s)     fault_q <= 1'b1;
  end

  assign run = supply_ok && !fault_q && !shut_s;

  fbs_ramp #(.FULL(FULL)) u_ramp (
    .clk(clk), .rst_n(rst_n), .run(run), .hold(hold_s),
    .ramp(ramp_q), .rising(rising_q)
  );

  fbs_phase #(.FULL(FULL), .DEAD(DEAD)) u_phase (
    .clk(clk), .rst_n(rst_n), .run(run), .hold(hold_s),
    .ramp(ramp_q), .rising(rising_q), .phase(phase_q)
  );

  assign gates   = gates_of(phase_q);
  assign drv_ls1 = gates.ls1;
  assign drv_ls2 = gates.ls2;
  assign drv_hs1 = gates.hs1;
  assign drv_hs2 = gates.hs2;

endmodule

// File: rtl/fbs_chk.sv
module fbs_chk
  import fbs_pkg::*;
#(
  parameter int unsigned FULL = 600,
  localparam int unsigned RW = $clog2(FULL + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          supply_ok,
  input logic          hold_s,
  input logic          fault,
  input logic [RW-1:0] ramp,
  input logic          ls1,
  input logic          ls2,
  input logic          hs1,
  input logic          hs2
);

  localparam logic [RW-1:0] SIXTH_V = RW'(lvl_sixth(FULL));
  localparam logic [RW-1:0] HIGH_V  = RW'(lvl_high(FULL));

  AST_LEG1_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ls1 && hs1)); // R5
  AST_LEG2_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ls2 && hs2)); // R5
  AST_PAIR_A_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ls1 && hs2) |=> !hs1); // R5
  AST_PAIR_B_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ls2 && hs1) |=> !hs2); // R5
  AST_PRE_NO_HS: assert property (@(posedge clk) disable iff (!rst_n)
    (ls1 && ls2) |=> !(hs1 || hs2)); // R3
  AST_UV_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !(ls1 || ls2 || hs1 || hs2)); // R1
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && supply_ok) |=> fault); // R6
  AST_FAULT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !(ls1 || ls2 || hs1 || hs2)); // R6
  AST_HOLD_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    hold_s |=> (ramp < SIXTH_V) && !(ls1 || ls2 || hs1 || hs2)); // R7
  AST_RAMP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ramp <= HIGH_V); // R8

endmodule

bind fb_bridge_seq fbs_chk #(.FULL(FULL)) u_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .hold_s(hold_s),
  .fault(fault_q), .ramp(ramp_q),
  .ls1(drv_ls1), .ls2(drv_ls2), .hs1(drv_hs1), .hs2(drv_hs2)
);

// File: tb/fb_bridge_seq_tb.sv
`timescale 1ns/1ps
module fb_bridge_seq_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b0;
  logic shut_req = 1'b0;
  logic hold_req = 1'b0;
  logic ls1, ls2, hs1, hs2;

  int n_chk = 0;
  int n_bad = 0;
  int pos = 0;
  int leg_viol = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fb_bridge_seq u_dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
    .shut_req(shut_req), .hold_req(hold_req),
    .drv_ls1(ls1), .drv_ls2(ls2), .drv_hs1(hs1), .drv_hs2(hs2)
  );

  // Defaults: FULL=600 -> low 200, high 400; DEAD=100. Pattern {ls1,ls2,hs1,hs2}.
  localparam int NV = 15;
  localparam int VK [NV] = '{0, 199, 200, 299, 300, 399, 400, 499,
                             500, 599, 600, 700, 799, 800, 900};
  localparam logic [3:0] VE [NV] = '{4'b1100, 4'b1100, 4'b0000, 4'b0000,
                                     4'b1001, 4'b1001, 4'b0000, 4'b0000,
                                     4'b0110, 4'b0110, 4'b0000, 4'b1001,
                                     4'b1001, 4'b0000, 4'b0110};
  localparam int VT [NV] = '{2, 8, 3, 3, 4, 4, 3, 3, 4, 4, 3, 4, 8, 3, 4};

  function automatic string tg(input int n);
    case (n)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input logic [3:0] exp, input string req);
    n_chk++;
    if ({ls1, ls2, hs1, hs2} !== exp) begin
      n_bad++;
      $display("FAIL %s at k=%0d: got %b expected %b", req, pos,
               {ls1, ls2, hs1, hs2}, exp);
    end
  endtask

  task automatic go(input int k);
    repeat (k - pos) @(posedge clk);
    @(negedge clk);
    pos = k;
  endtask

  always @(negedge clk)
    if (rst_n && ((ls1 && hs1) || (ls2 && hs2))) leg_viol++;

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // reset state
    repeat (3) @(negedge clk);
    check(4'b0000, "R1");
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(4'b0000, "R1");

    // table walk over a normal start and two periods
    supply_ok = 1'b1;
    pos = -1;
    for (int i = 0; i < NV; i++) begin
      go(VK[i]);
      check(VE[i], tg(VT[i]));
    end

    // R1: supply drop mid pair B
    go(950);
    check(4'b0110, "R4");
    supply_ok = 1'b0;
    go(951);
    check(4'b0000, "R1");
    go(960);
    supply_ok = 1'b1;
    pos = -1;
    go(0);
    check(4'b1100, "R1");

    // R7: hold during pair A, then release
    go(350);
    hold_req = 1'b1;
    go(352);
    check(4'b1001, "R7");
    go(353);
    check(4'b0000, "R7");
    go(420);
    check(4'b0000, "R7");
    hold_req = 1'b0;
    pos = -3;
    go(-1);
    check(4'b0000, "R7");
    go(0);
    check(4'b1100, "R7");
    go(199);
    check(4'b1100, "R7");
    go(200);
    check(4'b0000, "R7");
    go(300);
    check(4'b1001, "R7");

    // R6: latched shutdown during pair B
    go(550);
    check(4'b0110, "R6");
    shut_req = 1'b1;
    go(552);
    check(4'b0110, "R6");
    go(553);
    check(4'b0000, "R6");
    go(560);
    shut_req = 1'b0;
    go(1200);
    check(4'b0000, "R6");
    supply_ok = 1'b0;
    go(1201);
    supply_ok = 1'b1;
    pos = -1;
    go(0);
    check(4'b1100, "R6");
    go(300);
    check(4'b1001, "R6");

    // R9: hold release and shutdown reach the logic together
    hold_req = 1'b1;
    go(303);
    check(4'b0000, "R9");
    go(340);
    hold_req = 1'b0;
    shut_req = 1'b1;
    pos = -3;
    go(0);
    check(4'b0000, "R9");
    go(5);
    check(4'b0000, "R9");
    shut_req = 1'b0;
    go(250);
    check(4'b0000, "R9");
    supply_ok = 1'b0;
    go(251);
    supply_ok = 1'b1;
    pos = -1;
    go(0);
    check(4'b1100, "R9");

    // R5: leg exclusion over the whole run
    n_chk++;
    if (leg_viol != 0) begin
      n_bad++;
      $display("FAIL R5: got %0d leg overlaps expected 0", leg_viol);
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule